// File: doc/BRIEF.md
# Configurable Hazard Detection and Forwarding Unit

This block examines the instruction in the decode stage of a five-stage pipeline. It checks that instruction's source registers against the destinations of the instructions now in the execute and memory stages. When a later stage is about to write a register that decode needs, the unit either stalls decode or selects a forwarded value that bypasses the register file. The writeback stage is not checked, because the register file is assumed to pass a same-cycle write through to its read ports.

A two-bit mode input picks one of three policies: off, stall-only, or stall-with-forwarding. Each source operand carries two request flags. One says the ALU uses it. The other says a branch or jump-register resolved in decode uses it. The two uses follow different rules, because a branch resolved in decode cannot wait for a value from the execute stage. The unit is purely combinational. Its stall output holds the PC and the fetch register, and its bubble output makes the execute stage load a no-op in place of the decode latch.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A producer stage counts as a hazard only when three things hold: its write enable is 1, its destination is not register 0, and that destination equals a decode operand whose request flag is set. Otherwise stall is 0, both forward selects are 00, and both decode-forward flags are 0.
- R2: In stall-only mode (mode = 01), an ALU-operand hazard with either the execute or the memory stage sets stall to 1.
- R3: In forwarding mode (mode = 10), an ALU-operand hazard with the memory stage only sets that operand's select to 01 and its forwarded value to the memory result.
- R4: In forwarding mode, an ALU-operand hazard with a non-load execute instruction sets that operand's select to 10 and its value to the execute result. The execute stage wins when both stages match.
- R5: In forwarding mode, an ALU-operand hazard with an execute instruction whose load flag is 1 sets stall to 1.
- R6: In either active mode, a branch-operand hazard with the execute stage sets stall to 1, whether or not that instruction is a load.
- R7: In stall-only mode, a branch-operand hazard with the memory stage sets stall to 1.
- R8: In forwarding mode, a branch-operand hazard with the memory stage sets that operand's decode-forward flag to 1 and its value to the memory result, without a stall. Its ALU select is left at 00.
- R9: Mode 00 and mode 11 both turn the unit off: no stall, selects 00, flags 0, values 0.
- R10: The bubble output always equals stall. While stall is 1, every select, flag and forwarded value is 0. A forwarded value is 0 whenever its operand forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Policy: 00 off, 01 stall-only, 10 forwarding, 11 off |
| dec_rs | input | AW | First source register of the decode instruction |
| dec_rt | input | AW | Second source register of the decode instruction |
| dec_alu_rs | input | 1 | ALU reads the first source |
| dec_alu_rt | input | 1 | ALU reads the second source |
| dec_br_rs | input | 1 | Branch/jump-register logic reads the first source |
| dec_br_rt | input | 1 | Branch logic reads the second source |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | XLEN | ALU result in the execute stage |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | XLEN | Result value leaving the memory stage |
| stall | output | 1 | Hold PC and fetch register, drop the fetched word |
| bubble | output | 1 | Load a no-op into the execute stage |
| fwd_sel_rs | output | 2 | First operand ALU select: 00 none, 01 memory, 10 execute |
| fwd_sel_rt | output | 2 | Second operand ALU select, same encoding |
| m2d_rs | output | 1 | First operand forwarded from memory for a branch |
| m2d_rt | output | 1 | Second operand forwarded from memory for a branch |
| fwd_val_rs | output | XLEN | Forwarded value for the first operand |
| fwd_val_rt | output | XLEN | Forwarded value for the second operand |

## Verification
The bench builds the unit with a 16-bit data path and 4-bit register numbers. The narrow register field puts register 15, the highest register, in reach, so the match logic is checked at its top index as well as at register 0. The 16-bit results keep the execute and memory test values distinct. That makes a wrong source in a forwarded value show up in every data bit.

// File: rtl/hdu_pkg.sv
// Shared encodings for the hazard unit.
// Assumes a two-bit mode field and a two-bit forward select per operand.
package hdu_pkg;

    typedef enum logic [1:0] {
        HZ_OFF   = 2'b00,
        HZ_STALL = 2'b01,
        HZ_FWD   = 2'b10,
        HZ_RSVD  = 2'b11
    } hz_mode_e;

    typedef enum logic [1:0] {
        FW_NONE = 2'b00,
        FW_MEM  = 2'b01,
        FW_EXE  = 2'b10
    } fw_sel_e;

    localparam int NSRC  = 2;  // producer stages: 0 execute, 1 memory
    localparam int NKIND = 2;  // operand use kinds: 0 ALU, 1 branch

endpackage

// File: rtl/hdu_src_match.sv
// Compares one producer stage's destination with both decode operands for one use kind.
// Assumes register 0 is hard-wired, so a write to it never creates a dependency.
module hdu_src_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] rt,
    input  logic          use_rs,
    input  logic          use_rt,
    input  logic [AW-1:0] dst,
    input  logic          we,
    output logic          hit_rs,
    output logic          hit_rt
);
    logic live;

    // A producer is live only if it writes a real register.
    always_comb begin
        live   = we && (dst != '0);
        hit_rs = live && use_rs && (dst == rs);
        hit_rt = live && use_rt && (dst == rt);
    end
endmodule

// File: rtl/hdu_stall_ctl.sv
// Turns per-operand hit flags into the stall decision under the selected mode.
// Assumes the hit flags already exclude register 0 and disabled writes.
module hdu_stall_ctl
    import hdu_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] alu_ex_hit,
    input  logic [1:0] alu_mem_hit,
    input  logic [1:0] br_ex_hit,
    input  logic [1:0] br_mem_hit,
    input  logic       ex_load,
    output logic       stall,
    output logic       fwd_en
);
    logic active;
    logic fwd_mode;
    logic stall_only_cause;
    logic fwd_cause;

    // Decode the policy and combine the causes for each policy.
    always_comb begin
        fwd_mode         = (mode == HZ_FWD);
        active           = (mode == HZ_STALL) || fwd_mode;
        stall_only_cause = (|alu_ex_hit) || (|alu_mem_hit) || (|br_mem_hit);
        fwd_cause        = (|alu_ex_hit) && ex_load;
        stall            = active && ((|br_ex_hit) ||
                                      (fwd_mode ? fwd_cause : stall_only_cause));
        fwd_en           = fwd_mode && !stall;
    end
endmodule

// File: rtl/hdu_operand_pick.sv
// Chooses the forward select, decode-forward flag and value for one operand.
// Assumes en is low whenever the pipeline stalls or forwarding is off.
module hdu_operand_pick
    import hdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            en,
    input  logic            alu_ex,
    input  logic            alu_mem,
    input  logic            br_mem,
    input  logic [XLEN-1:0] ex_val,
    input  logic [XLEN-1:0] mem_val,
    output logic [1:0]      sel,
    output logic            m2d,
    output logic [XLEN-1:0] val
);
    // The newest producer wins; branch forwards come only from memory.
    always_comb begin
        sel = FW_NONE;
        m2d = 1'b0;
        val = '0;
        if (en) begin
            m2d = br_mem;
            if (alu_ex) begin
                sel = FW_EXE;
                val = ex_val;
            end else if (alu_mem) begin
                sel = FW_MEM;
                val = mem_val;
            end else if (br_mem) begin
                val = mem_val;
            end
        end
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Decode-stage hazard detection and forwarding for a five-stage pipeline.
// Assumes the register file forwards same-cycle writeback writes, so writeback is not checked.
module hazard_fwd_unit
    import hdu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [1:0]      mode,
    input  logic [AW-1:0]   dec_rs,
    input  logic [AW-1:0]   dec_rt,
    input  logic            dec_alu_rs,
    input  logic            dec_alu_rt,
    input  logic            dec_br_rs,
    input  logic            dec_br_rt,
    input  logic [AW-1:0]   ex_dst,
    input  logic            ex_we,
    input  logic            ex_load,
    input  logic [XLEN-1:0] ex_result,
    input  logic [AW-1:0]   mem_dst,
    input  logic            mem_we,
    input  logic [XLEN-1:0] mem_result,
    output logic            stall,
    output logic            bubble,
    output logic [1:0]      fwd_sel_rs,
    output logic [1:0]      fwd_sel_rt,
    output logic            m2d_rs,
    output logic            m2d_rt,
    output logic [XLEN-1:0] fwd_val_rs,
    output logic [XLEN-1:0] fwd_val_rt
);
    logic [AW-1:0]   src_dst  [NSRC];
    logic            src_we   [NSRC];
    logic [1:0]      use_rs   [NKIND];
    logic [1:0]      use_flag [NKIND];
    logic [1:0]      hit      [NSRC][NKIND];
    logic            fwd_en;
    logic [1:0]      sel_arr  [2];
    logic [1:0]      m2d_arr;
    logic [XLEN-1:0] val_arr  [2];
    logic [XLEN-1:0] ex_r, mem_r;

    // Gather producer stages and use flags into indexable form.
    always_comb begin
        src_dst[0]  = ex_dst;
        src_we[0]   = ex_we;
        src_dst[1]  = mem_dst;
        src_we[1]   = mem_we;
        use_flag[0] = {dec_alu_rt, dec_alu_rs};
        use_flag[1] = {dec_br_rt, dec_br_rs};
        use_rs[0]   = use_flag[0];
        use_rs[1]   = use_flag[1];
        ex_r        = ex_result;
        mem_r       = mem_result;
    end

    // One comparator pair per producer stage and use kind.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar k = 0; k < NKIND; k++) begin : g_kind
            hdu_src_match #(.AW(AW)) u_match (
                .rs     (dec_rs),
                .rt     (dec_rt),
                .use_rs (use_rs[k][0]),
                .use_rt (use_rs[k][1]),
                .dst    (src_dst[s]),
                .we     (src_we[s]),
                .hit_rs (hit[s][k][0]),
                .hit_rt (hit[s][k][1])
            );
        end
    end

    hdu_stall_ctl u_stall (
        .mode        (mode),
        .alu_ex_hit  (hit[0][0]),
        .alu_mem_hit (hit[1][0]),
        .br_ex_hit   (hit[0][1]),
        .br_mem_hit  (hit[1][1]),
        .ex_load     (ex_load),
        .stall       (stall),
        .fwd_en      (fwd_en)
    );

    // One selector per source operand: index 0 is rs, index 1 is rt.
    for (genvar o = 0; o < 2; o++) begin : g_opnd
        hdu_operand_pick #(.XLEN(XLEN)) u_pick (
            .en      (fwd_en),
            .alu_ex  (hit[0][0][o]),
            .alu_mem (hit[1][0][o]),
            .br_mem  (hit[1][1][o]),
            .ex_val  (ex_r),
            .mem_val (mem_r),
            .sel     (sel_arr[o]),
            .m2d     (m2d_arr[o]),
            .val     (val_arr[o])
        );
    end

    // Drive the outputs; the execute bubble follows the stall.
    always_comb begin
        bubble     = stall;
        fwd_sel_rs = sel_arr[0];
        fwd_sel_rt = sel_arr[1];
        m2d_rs     = m2d_arr[0];
        m2d_rt     = m2d_arr[1];
        fwd_val_rs = val_arr[0];
        fwd_val_rt = val_arr[1];
    end
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
// Checker for hazard_fwd_unit: relates its inputs to its outputs by the rules of the brief.
// Assumes purely combinational behaviour, so immediate assertions are used.
module hazard_fwd_unit_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic [1:0]      mode,
    input logic [AW-1:0]   dec_rs,
    input logic [AW-1:0]   dec_rt,
    input logic            dec_alu_rs,
    input logic            dec_alu_rt,
    input logic            dec_br_rs,
    input logic            dec_br_rt,
    input logic [AW-1:0]   ex_dst,
    input logic            ex_we,
    input logic            ex_load,
    input logic [XLEN-1:0] ex_result,
    input logic [AW-1:0]   mem_dst,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_result,
    input logic            stall,
    input logic            bubble,
    input logic [1:0]      fwd_sel_rs,
    input logic [1:0]      fwd_sel_rt,
    input logic            m2d_rs,
    input logic            m2d_rt,
    input logic [XLEN-1:0] fwd_val_rs,
    input logic [XLEN-1:0] fwd_val_rt
);
    logic ex_live, mem_live, ex_br, mem_br, ex_alu;

    // Evaluate every rule whenever any port changes.
    always_comb begin
        ex_live  = ex_we && (ex_dst != '0);
        mem_live = mem_we && (mem_dst != '0);
        ex_br    = ex_live && ((dec_br_rs && ex_dst == dec_rs) || (dec_br_rt && ex_dst == dec_rt));
        mem_br   = mem_live && ((dec_br_rs && mem_dst == dec_rs) || (dec_br_rt && mem_dst == dec_rt));
        ex_alu   = ex_live && ((dec_alu_rs && ex_dst == dec_rs) || (dec_alu_rt && ex_dst == dec_rt));

        a_r1_no_live_producer: assert (ex_live || mem_live ||
                                        (!stall && fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !m2d_rs && !m2d_rt))
            else $error("R1 hazard without a live producer");
        a_r2_stall_mode_no_fwd: assert (mode != 2'b01 || (fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !m2d_rs && !m2d_rt))
            else $error("R2 forward in stall-only mode");
        a_r3_mem_value: assert (fwd_sel_rs != 2'b01 || fwd_val_rs == mem_result)
            else $error("R3 rs memory value");
        a_r3_mem_value_rt: assert (fwd_sel_rt != 2'b01 || fwd_val_rt == mem_result)
            else $error("R3 rt memory value");
        a_r4_ex_value: assert ((fwd_sel_rs != 2'b10 || fwd_val_rs == ex_result) &&
                               (fwd_sel_rt != 2'b10 || fwd_val_rt == ex_result))
            else $error("R4 execute value");
        a_r5_load_stall: assert (!(mode == 2'b10 && ex_load && ex_alu) || stall)
            else $error("R5 load-use without stall");
        a_r6_branch_ex_stall: assert (!((mode == 2'b01 || mode == 2'b10) && ex_br) || stall)
            else $error("R6 branch on execute result without stall");
        a_r7_branch_mem_stall: assert (!(mode == 2'b01 && mem_br) || stall)
            else $error("R7 branch on memory result without stall");
        a_r8_m2d_value: assert ((!m2d_rs || fwd_val_rs == mem_result) && (!m2d_rt || fwd_val_rt == mem_result))
            else $error("R8 decode forward value");
        a_r9_off_quiet: assert ((mode == 2'b01 || mode == 2'b10) ||
                                (!stall && fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !m2d_rs && !m2d_rt))
            else $error("R9 activity while off");
        a_r10_bubble_squash: assert (!bubble || (fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 &&
                                                 !m2d_rs && !m2d_rt && fwd_val_rs == '0 && fwd_val_rt == '0))
            else $error("R10 forward during bubble");
    end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (.*);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
    localparam int XLEN = 16;
    localparam int AW   = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [1:0]      mode;
    logic [AW-1:0]   dec_rs, dec_rt, ex_dst, mem_dst;
    logic            dec_alu_rs, dec_alu_rt, dec_br_rs, dec_br_rt;
    logic            ex_we, ex_load, mem_we;
    logic [XLEN-1:0] ex_result, mem_result;
    logic            stall, bubble, m2d_rs, m2d_rt;
    logic [1:0]      fwd_sel_rs, fwd_sel_rt;
    logic [XLEN-1:0] fwd_val_rs, fwd_val_rt;

    hazard_fwd_unit #(.XLEN(XLEN), .AW(AW)) u0 (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  rs, rt;
        logic [3:0]  use_f;   // {alu_rs, alu_rt, br_rs, br_rt}
        logic [3:0]  exd;
        logic        exwe, exld;
        logic [15:0] exres;
        logic [3:0]  md;
        logic        mwe;
        logic [15:0] mres;
        logic        e_st;
        logic [1:0]  e_srs, e_srt;
        logic        e_mrs, e_mrt;
        logic [15:0] e_vrs, e_vrt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R1: write enables low
        '{2'd2,4'd3,4'd4,4'b1100,4'd3,1'b0,1'b0,16'hAAAA,4'd4,1'b0,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd1},
        // R1: destinations are register 0
        '{2'd2,4'd0,4'd0,4'b1111,4'd0,1'b1,1'b0,16'hAAAA,4'd0,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd1},
        // R1: match on an operand that is not requested
        '{2'd2,4'd3,4'd4,4'b0100,4'd3,1'b1,1'b0,16'hAAAA,4'd5,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd1},
        // R2: stall-only, execute hit on rs
        '{2'd1,4'd3,4'd4,4'b1000,4'd3,1'b1,1'b0,16'hAAAA,4'd9,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd2},
        // R2: stall-only, memory hit on rt
        '{2'd1,4'd3,4'd4,4'b0100,4'd9,1'b1,1'b0,16'hAAAA,4'd4,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd2},
        // R3: memory forward to rt
        '{2'd2,4'd3,4'd4,4'b1100,4'd7,1'b1,1'b0,16'hAAAA,4'd4,1'b1,16'h5555, 1'b0,2'd0,2'd1,1'b0,1'b0,16'h0,16'h5555,4'd3},
        // R4: execute wins over memory on rs
        '{2'd2,4'd3,4'd4,4'b1100,4'd3,1'b1,1'b0,16'hAAAA,4'd3,1'b1,16'h5555, 1'b0,2'd2,2'd0,1'b0,1'b0,16'hAAAA,16'h0,4'd4},
        // R4: both operands from execute
        '{2'd2,4'd6,4'd6,4'b1100,4'd6,1'b1,1'b0,16'hAAAA,4'd9,1'b1,16'h5555, 1'b0,2'd2,2'd2,1'b0,1'b0,16'hAAAA,16'hAAAA,4'd4},
        // R5: load-use stalls
        '{2'd2,4'd3,4'd4,4'b1000,4'd3,1'b1,1'b1,16'hAAAA,4'd9,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd5},
        // R5: load not matching, memory forward still used
        '{2'd2,4'd3,4'd4,4'b0100,4'd9,1'b1,1'b1,16'hAAAA,4'd4,1'b1,16'h5555, 1'b0,2'd0,2'd1,1'b0,1'b0,16'h0,16'h5555,4'd5},
        // R6: forwarding mode, branch on execute result
        '{2'd2,4'd3,4'd4,4'b0010,4'd3,1'b1,1'b0,16'hAAAA,4'd9,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd6},
        // R6: stall-only mode, branch rt on execute result
        '{2'd1,4'd3,4'd4,4'b0001,4'd4,1'b1,1'b0,16'hAAAA,4'd9,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd6},
        // R7: stall-only, branch on memory result
        '{2'd1,4'd3,4'd4,4'b0010,4'd9,1'b1,1'b0,16'hAAAA,4'd3,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd7},
        // R8: branch rt forwarded from memory
        '{2'd2,4'd3,4'd4,4'b0011,4'd9,1'b1,1'b0,16'hAAAA,4'd4,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b1,16'h0,16'h5555,4'd8},
        // R8: branch rs forwarded, ALU rt unaffected
        '{2'd2,4'd3,4'd4,4'b0110,4'd9,1'b1,1'b0,16'hAAAA,4'd3,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b1,1'b0,16'h5555,16'h0,4'd8},
        // R9: mode 00 off
        '{2'd0,4'd3,4'd4,4'b1100,4'd3,1'b1,1'b0,16'hAAAA,4'd4,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd9},
        // R9: mode 11 off
        '{2'd3,4'd3,4'd4,4'b0010,4'd3,1'b1,1'b0,16'hAAAA,4'd9,1'b1,16'h5555, 1'b0,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd9},
        // R10: stall squashes a pending memory forward
        '{2'd2,4'd3,4'd4,4'b1001,4'd4,1'b1,1'b0,16'hAAAA,4'd3,1'b1,16'h5555, 1'b1,2'd0,2'd0,1'b0,1'b0,16'h0,16'h0,4'd10},
        // R3: highest register number
        '{2'd2,4'd15,4'd4,4'b1000,4'd9,1'b1,1'b0,16'hAAAA,4'd15,1'b1,16'h5555, 1'b0,2'd1,2'd0,1'b0,1'b0,16'h5555,16'h0,4'd3}
    };

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic apply(input vec_t v);
        @(negedge clk);
        mode = v.mode; dec_rs = v.rs; dec_rt = v.rt;
        {dec_alu_rs, dec_alu_rt, dec_br_rs, dec_br_rt} = v.use_f;
        ex_dst = v.exd; ex_we = v.exwe; ex_load = v.exld; ex_result = v.exres;
        mem_dst = v.md; mem_we = v.mwe; mem_result = v.mres;
        #5;
    endtask

    task automatic check_outs(input vec_t v, input int idx);
        logic [53:0] act, exp;
        act = {stall, fwd_sel_rs, fwd_sel_rt, m2d_rs, m2d_rt, fwd_val_rs, fwd_val_rt};
        exp = {v.e_st, v.e_srs, v.e_srt, v.e_mrs, v.e_mrt, v.e_vrs, v.e_vrt};
        total++;
        if (act[38:0] !== exp[38:0]) begin
            bad++;
            $display("FAIL R%0d vector %0d: actual=%h expected=%h", v.req, idx, act[38:0], exp[38:0]);
        end
        // R10: bubble tracks stall on every vector
        total++;
        if (bubble !== v.e_st) begin
            bad++;
            $display("FAIL R10 vector %0d bubble: actual=%b expected=%b", idx, bubble, v.e_st);
        end
    endtask

    initial begin
        mode = 2'b00; dec_rs = '0; dec_rt = '0;
        {dec_alu_rs, dec_alu_rt, dec_br_rs, dec_br_rt} = 4'b0000;
        ex_dst = '0; ex_we = 0; ex_load = 0; ex_result = '0;
        mem_dst = '0; mem_we = 0; mem_result = '0;
        repeat (2) @(negedge clk);
        #5;
        // R9: idle state with the unit off
        total++;
        if ({stall, bubble, fwd_sel_rs, fwd_sel_rt, m2d_rs, m2d_rt} !== 8'h00 || fwd_val_rs !== '0 || fwd_val_rt !== '0) begin
            bad++;
            $display("FAIL R9 idle: actual=%b expected=00000000", {stall, bubble, fwd_sel_rs, fwd_sel_rt, m2d_rs, m2d_rt});
        end

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_outs(VECS[i], i);
        end

        // R1: directed, write to register 0 while a used operand is register 0
        begin
            vec_t v;
            v = VECS[1];
            v.mode = 2'd1;
            apply(v);
            check_outs(v, 100);
        end
        // R4: directed, execute load forwarding disabled by load flag only for ALU use
        begin
            vec_t v;
            v = VECS[6];
            v.exld = 1'b1; v.e_st = 1'b1; v.e_srs = 2'd0; v.e_vrs = 16'h0; v.req = 4'd5;
            apply(v);
            check_outs(v, 101);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule